// File: doc/BRIEF.md
# Set-Dueling Prefetch Granularity Selector

This block decides, for each request seen by a lower-level cache prefetcher, whether spatial prefetching should work at small-page (4KB) or huge-page (2MB) granularity. A request on a small page always gets small granularity. A request on a huge page may use either one, and the block resolves that choice by set dueling. Two small groups of cache sets are leaders: one group is fixed to small granularity and the other to huge granularity. Every other set is a follower and uses a shared 3-bit saturating counter to decide.

The counter learns from demand hits on prefetched blocks in the leader sets. A useful prefetch in a small-granularity leader moves the counter toward small granularity. A useful prefetch in a huge-granularity leader moves it toward huge granularity. The granularity output and the set class are combinational from the set index, the page-size bit and the current counter. The counter changes on the clock edge that follows a training event.

Top module: `gran_duel_sel`

## Requirements
- R1: On reset (synchronous, active-low `rst_n`) the counter is set to 4 (binary 100). A follower on a huge page then selects small granularity.
- R2: A set whose index bits [4:0] equal 0 is a small-page leader and reports class 2'b01. A set whose bits [4:0] equal 31 is a huge-page leader and reports class 2'b10. Every other set is a follower and reports class 2'b00.
- R3: A request with `req_huge`=0 always gets `gran_huge`=0 (small granularity), whatever its set and the counter value.
- R4: A huge-page request in a small-page leader set gets `gran_huge`=0. A huge-page request in a huge-page leader set gets `gran_huge`=1. The counter has no effect on either.
- R5: A huge-page request in a follower set gets `gran_huge` equal to the inverse of the counter's top bit. Top bit 1 selects small granularity and top bit 0 selects huge granularity.
- R6: A training event (`trn_vld`=1) whose set `trn_set` is a small-page leader raises the counter by one on the next clock edge. A training event whose set is a huge-page leader lowers it by one.
- R7: The counter saturates. It stays at 7 when raised and at 0 when lowered.
- R8: A training event in a follower set leaves the counter unchanged.
- R9: A raise and a lower requested in the same cycle (training on both ports, one in each kind of leader) cancel out, and the counter does not change.
- R10: `gran_huge` and `set_cls` change in the same cycle as `req_set` and `req_huge`, with no register in between. The counter value is exposed on `ctr_q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_set | input | 10 | Cache set index of the current request |
| req_huge | input | 1 | 1 when the request lies on a 2MB page |
| trn_vld | input | 2 | One valid bit per training port: a demand hit on a prefetched block |
| trn_set | input | 20 | Set index for each training port, 10 bits per port, port 0 in the low bits |
| gran_huge | output | 1 | 1 = prefetch at 2MB granularity, 0 = 4KB granularity |
| set_cls | output | 2 | Class of `req_set`: 00 follower, 01 small leader, 10 huge leader |
| ctr_q | output | 3 | Current value of the duel counter |

## Verification
The bench drives the counter to both ends and past them. A counter that wraps instead of saturating would flip the followers' choice at the moment it should hold steady. It also sends a raise and a lower in the same cycle, which catches a design that lets one of them win. The bench checks training in follower sets and requests on small pages in every class of set, to catch selection logic that ignores the page-size bit or treats followers as leaders. Leader decoding is checked at the boundary values 0 and 31 and at the values next to them, 1 and 30.

// File: rtl/gran_duel_pkg.sv
// Shared types for the set-dueling granularity selector.
// Assumes a two-bit class encoding that the top's ports also use.
package gran_duel_pkg;
    typedef enum logic [1:0] {
        CLS_FOLLOW = 2'b00,
        CLS_SMALL  = 2'b01,
        CLS_HUGE   = 2'b10
    } set_cls_e;
endpackage

// File: rtl/gran_set_class.sv
// Sorts a set index into follower, small-page leader or huge-page leader.
// The class depends only on the low LEAD_BITS bits of the index: all zeros
// marks a small-page leader and all ones marks a huge-page leader.
module gran_set_class #(
    parameter int SET_W     = 10,
    parameter int LEAD_BITS = 5
) (
    input  logic [SET_W-1:0]          set_idx,
    output gran_duel_pkg::set_cls_e   cls
);
    import gran_duel_pkg::*;
    localparam logic [LEAD_BITS-1:0] SMALL_KEY = '0;
    localparam logic [LEAD_BITS-1:0] HUGE_KEY  = '1;

    logic [LEAD_BITS-1:0] key;
    assign key = set_idx[LEAD_BITS-1:0];

    // Decode the leader key into a class.
    always_comb begin
        if (key == SMALL_KEY)     cls = CLS_SMALL;
        else if (key == HUGE_KEY) cls = CLS_HUGE;
        else                      cls = CLS_FOLLOW;
    end
endmodule

// File: rtl/gran_duel_ctr.sv
// Saturating duel counter. Raise and lower requests in the same cycle cancel.
// Assumes a synchronous active-low reset to RST_VAL.
module gran_duel_ctr #(
    parameter int CTR_W   = 3,
    parameter int RST_VAL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up,
    input  logic             dn,
    output logic [CTR_W-1:0] ctr
);
    localparam logic [CTR_W-1:0] CMAX = '1;
    localparam logic [CTR_W-1:0] CMIN = '0;
    localparam logic [CTR_W-1:0] CRST = CTR_W'(RST_VAL);

    logic [CTR_W-1:0] ctr_nxt;

    // Work out the next value with saturation at both ends.
    always_comb begin
        ctr_nxt = ctr;
        if (up && !dn && ctr != CMAX)      ctr_nxt = ctr + 1'b1;
        else if (dn && !up && ctr != CMIN) ctr_nxt = ctr - 1'b1;
    end

    // Register the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) ctr <= CRST;
        else        ctr <= ctr_nxt;
    end

    // R7
    // no_wrap_chk: the counter never jumps between its two ends
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(($past(ctr) == CMAX && ctr == CMIN) || ($past(ctr) == CMIN && ctr == CMAX)));
    // R9
    // cancel_chk: simultaneous raise and lower hold the value
    cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up && dn) |=> $stable(ctr));
    // R8
    // idle_chk: no request, no change
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!up && !dn) |=> $stable(ctr));
endmodule

// File: rtl/gran_duel_sel.sv
// Top of the set-dueling granularity selector.
// Classifies the request set and each training set, folds training events into
// raise and lower requests for the duel counter, and picks the granularity.
// Assumes at most one training event per port per cycle.
module gran_duel_sel #(
    parameter int SET_W     = 10,
    parameter int LEAD_BITS = 5,
    parameter int CTR_W     = 3,
    parameter int N_TRN     = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SET_W-1:0]       req_set,
    input  logic                   req_huge,
    input  logic [N_TRN-1:0]       trn_vld,
    input  logic [N_TRN*SET_W-1:0] trn_set,
    output logic                   gran_huge,
    output logic [1:0]             set_cls,
    output logic [CTR_W-1:0]       ctr_q
);
    import gran_duel_pkg::*;
    localparam int RST_VAL = 1 << (CTR_W-1);

    set_cls_e         req_cls;
    set_cls_e         t_cls [N_TRN];
    logic [N_TRN-1:0] t_up, t_dn;
    logic             up, dn;

    gran_set_class #(.SET_W(SET_W), .LEAD_BITS(LEAD_BITS)) u_req_cls (
        .set_idx(req_set), .cls(req_cls));

    for (genvar g = 0; g < N_TRN; g++) begin : g_trn
        gran_set_class #(.SET_W(SET_W), .LEAD_BITS(LEAD_BITS)) u_cls (
            .set_idx(trn_set[g*SET_W +: SET_W]), .cls(t_cls[g]));
        assign t_up[g] = trn_vld[g] && (t_cls[g] == CLS_SMALL);
        assign t_dn[g] = trn_vld[g] && (t_cls[g] == CLS_HUGE);
    end

    assign up = |t_up;
    assign dn = |t_dn;

    gran_duel_ctr #(.CTR_W(CTR_W), .RST_VAL(RST_VAL)) u_ctr (
        .clk(clk), .rst_n(rst_n), .up(up), .dn(dn), .ctr(ctr_q));

    // Choose the granularity from the page size, the set class and the counter.
    always_comb begin
        if (!req_huge)                  gran_huge = 1'b0;
        else if (req_cls == CLS_SMALL)  gran_huge = 1'b0;
        else if (req_cls == CLS_HUGE)   gran_huge = 1'b1;
        else                            gran_huge = ~ctr_q[CTR_W-1];
    end

    assign set_cls = req_cls;

    // R3
    // small_page_chk: small pages never use huge granularity
    small_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_huge |-> !gran_huge);
    // R4
    // leader_fix_chk: leaders follow their fixed choice on huge pages
    leader_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_huge && set_cls != 2'b00) |-> (gran_huge == set_cls[1]));
    // R6
    // up_step_chk: a lone raise below the top adds exactly one
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up && !dn && ctr_q != '1) |=> ctr_q == $past(ctr_q) + 1'b1);
    // R6
    // dn_step_chk: a lone lower above zero subtracts exactly one
    dn_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn && !up && ctr_q != '0) |=> ctr_q == $past(ctr_q) - 1'b1);
    // R2
    // cls_onehot_chk: a class code never has both leader bits set
    cls_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_cls));
endmodule

// File: tb/gran_duel_sel_tb.sv
module gran_duel_sel_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [9:0]  req_set = 0;
    logic        req_huge = 0;
    logic [1:0]  trn_vld = 0;
    logic [19:0] trn_set = 0;
    logic        gran_huge;
    logic [1:0]  set_cls;
    logic [2:0]  ctr_q;
    int n_chk = 0, n_fail = 0;
    int model = 4;
    bit done = 0;

    always #10 clk = ~clk;

    gran_duel_sel u_dut (.clk, .rst_n, .req_set, .req_huge, .trn_vld,
        .trn_set, .gran_huge, .set_cls, .ctr_q);

    function automatic int cls_of(input logic [9:0] s);
        if (s[4:0] == 5'd0)  return 1;
        if (s[4:0] == 5'd31) return 2;
        return 0;
    endfunction

    function automatic bit gran_of(input logic [9:0] s, input bit hg, input int c);
        if (!hg) return 0;
        if (cls_of(s) == 1) return 0;
        if (cls_of(s) == 2) return 1;
        return (c < 4);
    endfunction

    task automatic chk(input string r, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    // check combinational outputs for a request (R10: same-cycle)
    task automatic probe(input string r, input logic [9:0] s, input bit hg);
        req_set = s; req_huge = hg;
        #1;
        chk({r, " gran"}, gran_huge, gran_of(s, hg, model));
        chk({r, " cls"}, set_cls, cls_of(s));
    endtask

    // one clock with training; model updated per requirements
    task automatic train(input logic [1:0] v, input logic [9:0] s0, input logic [9:0] s1);
        int u, d;
        @(negedge clk);
        trn_vld = v; trn_set = {s1, s0};
        u = (v[0] && cls_of(s0) == 1) || (v[1] && cls_of(s1) == 1);
        d = (v[0] && cls_of(s0) == 2) || (v[1] && cls_of(s1) == 2);
        @(negedge clk);
        trn_vld = 0;
        if (u && !d && model < 7) model++;
        else if (d && !u && model > 0) model--;
        chk("R6/R7/R8/R9 ctr", ctr_q, model);
    endtask

    initial begin
        #4000000;
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset ctr", ctr_q, 4);
        probe("R1 follower", 10'd5, 1);
        probe("R2 edge0", 10'd32, 1);
        probe("R2 edge1", 10'd1, 1);
        probe("R2 edge30", 10'd30, 1);
        probe("R2 edge31", 10'd63, 1);
        probe("R3 small leader", 10'd0, 0);
        probe("R3 huge leader", 10'd31, 0);
        probe("R3 follower", 10'd7, 0);
        // R7 saturate high
        repeat (6) train(2'b01, 10'd64, 10'd0);
        probe("R5 top", 10'd9, 1);
        // R7 saturate low
        repeat (10) train(2'b10, 10'd0, 10'd95);
        probe("R5 bottom", 10'd9, 1);
        probe("R4 small leader", 10'd0, 1);
        probe("R4 huge leader", 10'd31, 1);
        train(2'b01, 10'd32, 10'd0);
        train(2'b01, 10'd32, 10'd0);
        // R9 cancel
        train(2'b11, 10'd0, 10'd31);
        train(2'b11, 10'd127, 10'd96);
        // R8 followers
        train(2'b11, 10'd3, 10'd40);
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [9:0] a, b;
            a = 10'($urandom); b = 10'($urandom);
            if ($urandom % 3 == 0) a[4:0] = 5'd0;
            if ($urandom % 3 == 0) b[4:0] = 5'd31;
            train(2'($urandom), a, b);
            probe("R5 rand", 10'($urandom), 1'($urandom));
        end
        // reset mid-run: R1
        @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1; model = 4;
        chk("R1 re-reset", ctr_q, 4);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule